// File: doc/BRIEF.md
# SPI Command Buffer Target

This block is an SPI target that lets a microcontroller fill and drain an on-chip byte buffer over a four-wire serial link. The link runs in mode 3: SCLK idles high, the block samples MOSI on the rising edge and changes MISO after the falling edge, and bytes travel most significant bit first. SCLK, chip select and MOSI are brought into the system clock through two-flop synchronisers, and all edge detection works on the synchronised SCLK.

Each chip-select assertion carries one command. Its first byte is an opcode. The opcode selects one of these actions:

- return an identification byte;
- store a burst of payload bytes into the buffer;
- stream the buffer back;
- report the payload length of the last store;
- report a completion status.

Every reply byte sits at a fixed position in the frame. The header bytes and the turnaround byte read as zero. Raising chip select ends the command at any point. The buffer keeps its contents across commands.

Top module: `spi_cmd_buffer`

## Requirements
- R1: The link is SPI mode 3, most significant bit first. MOSI is sampled on the synchronised SCLK rising edge. MISO changes only after a synchronised SCLK falling edge or while chip select is high. The SCLK period is at least 8 system clocks.
- R2: Opcode 0x01 (identify) returns ID_VALUE (default 0x01) as byte index 4 of the frame. Byte index 0 is the opcode byte. All other bytes of the frame read 0x00.
- R3: Opcode 0x04 (store) treats byte indices 1 and 2 as address bytes and ignores them. Bytes from index 3 onward are written to buffer addresses 0, 1, 2 and so on. Payload bytes beyond DEPTH are ignored, including the trailing pad byte.
- R4: Opcode 0x07 (fetch) returns 0x00 for byte indices 0 to 3, where index 3 is the turnaround byte. Buffer bytes 0 to DEPTH-1 follow in order from index 4. Every byte after the buffer end reads 0x00.
- R5: Opcodes 0x02 and 0x05 return the payload count of the last store as a 16-bit value. The most significant byte is at index 4 and the least significant byte at index 5. All other bytes read 0x00.
- R6: Opcode 0x06 returns a status byte at index 4. Bit 0 is set only if the last store reached DEPTH payload bytes. The other bits read 0.
- R7: Opcode 0x03 and every opcode outside 0x01 to 0x07 return 0x00 for all bytes. They leave the buffer, the length and the status unchanged.
- R8: Raising chip select aborts the current command, and the next frame decodes a fresh opcode. A store cut short keeps the bytes it already wrote and reports their count. Buffer bytes it did not reach keep their old values.
- R9: After reset, MISO is 0, the stored length is 0 and the status bit is 0.
- R10: While chip select is high, MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock from the master, idles high |
| cs_n | input | 1 | Active-low chip select, held low for a whole command |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |

## Verification
The buffer is filled with four payload patterns: an incrementing count, a descending count, alternating 0x55/0xAA, and a multiplicative sequence. Each fill is read back byte for byte, which separates address ordering errors from bit ordering and data path errors. Full stores that run past the buffer end show whether the pad byte overwrites address 0. A store cut off by chip select, an opcode cut off mid-byte, and the reserved or unknown opcodes are each followed by length, status and read-back frames. These frames show what was kept and what was left untouched.

// File: rtl/spi_cmd_buffer.sv
module spi_cmd_buffer #(
  parameter int         DEPTH    = 1024,
  parameter logic [7:0] ID_VALUE = 8'h01
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int CW = $clog2(DEPTH + 8) + 1;
  localparam logic [CW-1:0] CNT_MAX  = '1;
  localparam logic [CW-1:0] IDX_PAY  = CW'(3);
  localparam logic [CW-1:0] IDX_RSP  = CW'(4);
  localparam logic [CW-1:0] IDX_RSP2 = CW'(5);
  localparam logic [CW-1:0] RD_END   = CW'(DEPTH + 4);
  localparam logic [LW-1:0] LEN_MAX  = LW'(DEPTH);
  localparam logic [7:0] OP_ID = 8'h01, OP_WLEN = 8'h02, OP_WDATA = 8'h04,
                         OP_RLEN = 8'h05, OP_RSTATE = 8'h06, OP_RDATA = 8'h07;

  logic [2:0]    sclk_q;
  logic [1:0]    cs_q, mosi_q;
  logic [2:0]    bit_cnt;
  logic [CW-1:0] byte_cnt;
  logic [6:0]    rx_sh;
  logic [7:0]    tx_sh, tx_next, opcode;
  logic [LW-1:0] wr_len;
  logic          full;
  logic [7:0]    mem [DEPTH];
  logic [15:0]   len16;

  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire sclk_fall = ~sclk_q[1] & sclk_q[2];
  wire active    = ~cs_q[1];
  wire [7:0] rx_byte  = {rx_sh, mosi_q[1]};
  wire byte_done      = active & sclk_rise & (bit_cnt == 3'd7);
  wire mem_we         = byte_done & (byte_cnt >= IDX_PAY) & (opcode == OP_WDATA) & (wr_len < LEN_MAX);
  wire [AW-1:0] rd_addr = AW'(byte_cnt - IDX_RSP);
  wire in_rd          = (byte_cnt >= IDX_RSP) && (byte_cnt < RD_END);

  assign len16 = 16'(wr_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 3'b111;
      cs_q   <= 2'b11;
      mosi_q <= 2'b00;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  always_comb begin
    tx_next = 8'h00;
    if (byte_cnt != '0) begin
      case (opcode)
        OP_ID:           if (byte_cnt == IDX_RSP) tx_next = ID_VALUE;
        OP_WLEN, OP_RLEN: begin
          if (byte_cnt == IDX_RSP)  tx_next = len16[15:8];
          if (byte_cnt == IDX_RSP2) tx_next = len16[7:0];
        end
        OP_RSTATE:       if (byte_cnt == IDX_RSP) tx_next = {7'b0, full};
        OP_RDATA:        if (in_rd) tx_next = mem[rd_addr];
        default:         tx_next = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      opcode   <= '0;
      wr_len   <= '0;
      full     <= 1'b0;
      miso     <= 1'b0;
    end else if (!active) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      opcode   <= '0;
      miso     <= 1'b0;
    end else begin
      if (sclk_rise) begin
        rx_sh   <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + CW'(1);
          if (byte_cnt == '0) begin
            opcode <= rx_byte;
            if (rx_byte == OP_WDATA) begin
              wr_len <= '0;
              full   <= 1'b0;
            end
          end else if (mem_we) begin
            wr_len <= wr_len + LW'(1);
            full   <= (wr_len == LEN_MAX - LW'(1));
          end
        end
      end
      if (sclk_fall) begin
        if (bit_cnt == 3'd0) begin
          miso  <= tx_next[7];
          tx_sh <= {tx_next[6:0], 1'b0};
        end else begin
          miso  <= tx_sh[7];
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_len[AW-1:0]] <= rx_byte;
  end

  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_len <= LEN_MAX);

  p_full_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> wr_len == LEN_MAX);

  p_len_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_len != $past(wr_len)) |-> (wr_len == $past(wr_len) + LW'(1) || wr_len == '0));

  p_miso_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (miso != $past(miso)) |-> ($past(sclk_fall) || $past(cs_q[1])));

  p_keep_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(opcode) != OP_WDATA && opcode != OP_WDATA) |-> ($stable(wr_len) && $stable(full)));

  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_q[1]) && cs_q[1]) |-> !miso);
endmodule

// File: tb/spi_cmd_buffer_tb.sv
module spi_cmd_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;
  localparam int HALF       = 5;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  int   total = 0, bad = 0;
  logic [7:0] txb [64];
  logic [7:0] rxb [64];
  logic [7:0] model [DEPTH];
  int   model_len = 0;
  int   model_full = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_buffer #(.DEPTH(DEPTH), .ID_VALUE(8'h01)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half_bit();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame(input int n);
    cs_n = 1'b0;
    half_bit();
    for (int k = 0; k < n; k++)
      for (int b = 7; b >= 0; b--) begin
        sclk = 1'b0;
        mosi = txb[k][b];
        half_bit();
        rxb[k][b] = miso;
        sclk = 1'b1;
        half_bit();
      end
    half_bit();
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int kind, input int i);
    case (kind)
      0: return 8'(i % 256);
      1: return 8'(255 - i);
      2: return (i % 2) ? 8'hAA : 8'h55;
      default: return 8'(i * 37 + 11);
    endcase
  endfunction

  task automatic clear_tx();
    for (int k = 0; k < 64; k++) txb[k] = 8'h00;
  endtask

  task automatic store(input int kind, input int n, input int extra);
    clear_tx();
    txb[0] = 8'h04; txb[1] = 8'h12; txb[2] = 8'h34;
    for (int i = 0; i < n; i++) txb[3+i] = pat(kind, i);
    for (int i = 0; i < extra; i++) txb[3+n+i] = 8'hE0 + 8'(i);
    frame(3 + n + extra);
    for (int i = 0; i < n && i < DEPTH; i++) model[i] = pat(kind, i);
    model_len  = (n < DEPTH) ? n : DEPTH;
    model_full = (n >= DEPTH) ? 1 : 0;
  endtask

  task automatic fetch_check(input string req);
    clear_tx();
    txb[0] = 8'h07;
    frame(DEPTH + 6);
    for (int k = 0; k < 4; k++) check("R4 header", int'(rxb[k]), 0);
    for (int i = 0; i < DEPTH; i++) check(req, int'(rxb[4+i]), int'(model[i]));
    check("R4 past end", int'(rxb[DEPTH+4]), 0);
    check("R4 past end", int'(rxb[DEPTH+5]), 0);
  endtask

  task automatic len_check(input logic [7:0] op, input string req);
    clear_tx();
    txb[0] = op;
    frame(7);
    check("R5 hdr", int'(rxb[3]), 0);
    check(req, int'(rxb[4]), (model_len >> 8) & 255);
    check(req, int'(rxb[5]), model_len & 255);
    check("R5 tail", int'(rxb[6]), 0);
  endtask

  task automatic state_check(input string req);
    clear_tx();
    txb[0] = 8'h06;
    frame(6);
    check(req, int'(rxb[4]), model_full);
    check("R6 tail", int'(rxb[5]), 0);
  endtask

  task automatic null_op(input logic [7:0] op);
    clear_tx();
    txb[0] = op;
    for (int k = 1; k < 12; k++) txb[k] = 8'hFF;
    frame(12);
    for (int k = 0; k < 12; k++) check("R7 reply", int'(rxb[k]), 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    check("R9 miso reset", int'(miso), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 idle miso", int'(miso), 0);
    len_check(8'h02, "R9 length after reset");
    state_check("R9 status after reset");

    clear_tx();
    txb[0] = 8'h01;
    frame(5);
    for (int k = 0; k < 4; k++) check("R2 ID filler", int'(rxb[k]), 0);
    check("R1 R2 ID byte", int'(rxb[4]), 1);

    for (int kind = 0; kind < 4; kind++) begin
      store(kind, DEPTH, 1 + kind);
      fetch_check("R3 R4 readback");
      len_check(8'h02, "R5 length 0x02");
      len_check(8'h05, "R5 length 0x05");
      state_check("R6 full status");
    end

    cs_n = 1'b0;
    half_bit();
    for (int b = 7; b >= 4; b--) begin
      sclk = 1'b0; mosi = 1'(8'h04 >> b); half_bit();
      sclk = 1'b1; half_bit();
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R10 idle after abort", int'(miso), 0);
    clear_tx();
    txb[0] = 8'h01;
    frame(5);
    check("R8 fresh opcode", int'(rxb[4]), 1);
    len_check(8'h05, "R8 length kept after abort");

    store(0, 10, 0);
    len_check(8'h02, "R8 partial length");
    state_check("R8 R6 partial status");
    fetch_check("R8 partial readback");

    null_op(8'h03);
    null_op(8'h09);
    null_op(8'hA5);
    len_check(8'h02, "R7 length kept");
    state_check("R7 status kept");
    fetch_check("R7 buffer kept");

    check("R10 final idle", int'(miso), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule